// File: doc/BRIEF.md
# Audio Ring-Buffer Index Controller

This block keeps the index state for two circular sample buffers held in system memory: one that collects captured audio (receive) and one that feeds playback (transmit). Software programs each direction through a small 32-bit register bus. It sets an enable bit, a buffer start address and a buffer length in bytes, and it owns one index of each pair. The controller owns the other index and moves it by one 32-bit sample each time the data path reports a finished word.

On the receive side the controller is the producer. It raises a store request while one more sample can be written without the producer index landing on the consumer index, so the ring never fills. On the transmit side the controller is the consumer. It raises a fetch request while the two indices differ, and equal indices mean the ring is empty. Each request carries the memory address of the current slot, which is the start address plus the index. A write-only soft-reset register returns the indices of either direction to zero. It leaves that direction's programming in place.

Top module: `audio_ring_ctrl`

## Requirements
- R1: The word registers sit at these byte offsets:
  - 0x00: transmit enable, bit 0.
  - 0x04: transmit start address.
  - 0x08: transmit length.
  - 0x0C: transmit producer index.
  - 0x10: transmit consumer index.
  - 0x14: receive enable, bit 0.
  - 0x18: receive start address.
  - 0x1C: receive length.
  - 0x20: receive producer index.
  - 0x24: receive consumer index.
  - 0x2C: soft reset.

  Reads are combinational from `reg_addr`. The soft-reset offset and every unmapped offset read zero. An access whose two low address bits are not zero reaches no register and reads zero.
- R2: After reset every register reads zero and neither request is raised.
- R3: A receive store request carries the address start + producer index. A `rx_store_ack` seen at a clock edge while the request is high moves the producer index to (index + 4) & (length − 1).
- R4: `rx_store_req` is high exactly when receive is enabled and (producer + 4) & (length − 1) differs from the consumer index. The ring therefore never becomes full, and the producer resumes once software moves the consumer index.
- R5: `tx_fetch_req` is high exactly when transmit is enabled and producer differs from consumer. Equal indices mean the ring is empty. The fetch address is start + consumer index. An ack while the request is high moves the consumer index to (index + 4) & (length − 1).
- R6: Writing 0 to an enable drops that request from the next cycle on. An ack that arrives while its request is low changes nothing.
- R7: Writes to the indices the controller owns have no effect. These are the receive producer at 0x20 and the transmit consumer at 0x10.
- R8: Writing the soft-reset register clears both indices of the receive side when bit 0 is set, and of the transmit side when bit 1 is set. The clear overrides an advance in the same cycle. Enable, start address and length are kept.
- R9: Indices wrap at the programmed power-of-two length. Lengths up to 0x200000 bytes are held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| tx_fetch_req | output | 1 | Playback sample fetch wanted |
| tx_fetch_ack | input | 1 | One playback word has been transferred |
| tx_fetch_addr | output | 32 | Memory address of the playback slot |
| rx_store_req | output | 1 | Capture sample store allowed |
| rx_store_ack | input | 1 | One capture word has been transferred |
| rx_store_addr | output | 32 | Memory address of the capture slot |

## Verification
The bench keeps the default parameters: 21-bit indices, 22-bit lengths, 32-bit addresses and a 4-byte step. With these it can program the full 0x200000 length while running the ring with lengths of 16 to 64 bytes. Small lengths bring the wrap, the one-slot-short stall on receive and the empty state on transmit within a few cycles. The random phase therefore crosses these boundaries many times, with enable toggles, soft resets and stray writes to the controller-owned indices mixed in.

// File: rtl/arc_pkg.sv
package arc_pkg;
  // direction slots used across the block
  localparam int DIR_TX = 0;
  localparam int DIR_RX = 1;
  localparam int NDIR   = 2;

  // register word numbers (byte offset / 4); software depends on these
  localparam int BLK_TX     = 0;
  localparam int BLK_RX     = 5;
  localparam int OFS_EN     = 0;
  localparam int OFS_START  = 1;
  localparam int OFS_LEN    = 2;
  localparam int OFS_PROD   = 3;
  localparam int OFS_CONS   = 4;
  localparam int WORD_SRST  = 11;
  localparam int SRST_RX_BIT = 0;
  localparam int SRST_TX_BIT = 1;

  function automatic int blk_of(input int dir);
    return (dir == DIR_RX) ? BLK_RX : BLK_TX;
  endfunction

  // index written by software: producer for playback, consumer for capture
  function automatic int sw_ofs(input int dir);
    return (dir == DIR_RX) ? OFS_CONS : OFS_PROD;
  endfunction

  function automatic int hw_ofs(input int dir);
    return (dir == DIR_RX) ? OFS_PROD : OFS_CONS;
  endfunction

  function automatic int srst_bit(input int dir);
    return (dir == DIR_RX) ? SRST_RX_BIT : SRST_TX_BIT;
  endfunction

  // next ring position for a power-of-two length
  function automatic logic [31:0] ring_next(input logic [31:0] idx,
                                            input logic [31:0] len,
                                            input logic [31:0] step);
    return (idx + step) & (len - 32'd1);
  endfunction
endpackage

// File: rtl/arc_regfile.sv
module arc_regfile #(
  parameter int REG_AW = 6,
  parameter int BUS_W  = 32,
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 21,
  parameter int SIZE_W = 22
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   bus_wen,
  input  logic [REG_AW-1:0]                      bus_addr,
  input  logic [BUS_W-1:0]                       bus_wdata,
  output logic [BUS_W-1:0]                       bus_rdata,
  input  logic [arc_pkg::NDIR-1:0][IDX_W-1:0]    hw_idx,
  output logic [arc_pkg::NDIR-1:0]               cfg_en,
  output logic [arc_pkg::NDIR-1:0][ADDR_W-1:0]   cfg_start,
  output logic [arc_pkg::NDIR-1:0][SIZE_W-1:0]   cfg_len,
  output logic [arc_pkg::NDIR-1:0][IDX_W-1:0]    sw_idx,
  output logic [arc_pkg::NDIR-1:0]               srst,
  output logic [arc_pkg::NDIR-1:0]               sw_wr
);
  localparam int WORD_W = REG_AW - 2;

  logic [WORD_W-1:0] word;
  logic              aligned;
  assign word    = bus_addr[REG_AW-1:2];
  assign aligned = (bus_addr[1:0] == 2'b00);

  function automatic logic hit(input logic [WORD_W-1:0] w, input int num);
    return int'(w) == num;
  endfunction

  logic wr_ok;
  assign wr_ok = bus_wen && aligned;

  for (genvar d = 0; d < arc_pkg::NDIR; d++) begin : g_dir
    localparam int BLK = arc_pkg::blk_of(d);
    localparam int SWO = arc_pkg::sw_ofs(d);
    logic              en_q;
    logic [ADDR_W-1:0] start_q;
    logic [SIZE_W-1:0] len_q;
    logic [IDX_W-1:0]  sw_q;
    logic              srst_w;
    logic              swwr_w;

    assign srst_w = wr_ok && hit(word, arc_pkg::WORD_SRST) &&
                    bus_wdata[arc_pkg::srst_bit(d)];
    assign swwr_w = wr_ok && hit(word, BLK + SWO);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        en_q    <= 1'b0;
        start_q <= '0;
        len_q   <= '0;
        sw_q    <= '0;
      end else begin
        if (wr_ok && hit(word, BLK + arc_pkg::OFS_EN))    en_q    <= bus_wdata[0];
        if (wr_ok && hit(word, BLK + arc_pkg::OFS_START)) start_q <= bus_wdata[ADDR_W-1:0];
        if (wr_ok && hit(word, BLK + arc_pkg::OFS_LEN))   len_q   <= bus_wdata[SIZE_W-1:0];
        if (srst_w)      sw_q <= '0;
        else if (swwr_w) sw_q <= bus_wdata[IDX_W-1:0];
      end
    end

    assign cfg_en[d]    = en_q;
    assign cfg_start[d] = start_q;
    assign cfg_len[d]   = len_q;
    assign sw_idx[d]    = sw_q;
    assign srst[d]      = srst_w;
    assign sw_wr[d]     = swwr_w;
  end

  always_comb begin
    bus_rdata = '0;
    if (aligned) begin
      for (int d = 0; d < arc_pkg::NDIR; d++) begin
        if (hit(word, arc_pkg::blk_of(d) + arc_pkg::OFS_EN))
          bus_rdata = BUS_W'(cfg_en[d]);
        if (hit(word, arc_pkg::blk_of(d) + arc_pkg::OFS_START))
          bus_rdata = BUS_W'(cfg_start[d]);
        if (hit(word, arc_pkg::blk_of(d) + arc_pkg::OFS_LEN))
          bus_rdata = BUS_W'(cfg_len[d]);
        if (hit(word, arc_pkg::blk_of(d) + arc_pkg::sw_ofs(d)))
          bus_rdata = BUS_W'(sw_idx[d]);
        if (hit(word, arc_pkg::blk_of(d) + arc_pkg::hw_ofs(d)))
          bus_rdata = BUS_W'(hw_idx[d]);
      end
    end
  end
endmodule

// File: rtl/arc_ring_engine.sv
module arc_ring_engine #(
  parameter int IDX_W       = 21,
  parameter int SIZE_W      = 22,
  parameter int ADDR_W      = 32,
  parameter int STEP        = 4,
  parameter bit HW_PRODUCES = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [ADDR_W-1:0] start,
  input  logic [SIZE_W-1:0] len,
  input  logic [IDX_W-1:0]  sw_idx,
  input  logic              srst,
  input  logic              xfer_ack,
  output logic [IDX_W-1:0]  hw_idx,
  output logic              req,
  output logic [ADDR_W-1:0] slot_addr,
  output logic              adv
);
  logic [IDX_W-1:0] idx_q;
  logic [31:0]      nxt32;
  logic [IDX_W-1:0] nxt;

  assign nxt32 = arc_pkg::ring_next(32'(idx_q), 32'(len), 32'(STEP));
  assign nxt   = nxt32[IDX_W-1:0];

  if (HW_PRODUCES) begin : g_producer
    // keep one slot free: never step onto the consumer
    assign req = en && (nxt != sw_idx);
  end else begin : g_consumer
    // equal indices mean nothing left to fetch
    assign req = en && (idx_q != sw_idx);
  end

  assign adv = req && xfer_ack;

  always_ff @(posedge clk) begin
    if (!rst_n)      idx_q <= '0;
    else if (srst)   idx_q <= '0;
    else if (adv)    idx_q <= nxt;
  end

  assign hw_idx    = idx_q;
  assign slot_addr = start + ADDR_W'(idx_q);
endmodule

// File: rtl/audio_ring_ctrl.sv
module audio_ring_ctrl #(
  parameter int REG_AW     = 6,
  parameter int BUS_W      = 32,
  parameter int ADDR_W     = 32,
  parameter int IDX_W      = 21,
  parameter int STEP_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wen,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [BUS_W-1:0]  reg_wdata,
  output logic [BUS_W-1:0]  reg_rdata,
  output logic              tx_fetch_req,
  input  logic              tx_fetch_ack,
  output logic [ADDR_W-1:0] tx_fetch_addr,
  output logic              rx_store_req,
  input  logic              rx_store_ack,
  output logic [ADDR_W-1:0] rx_store_addr
);
  localparam int SIZE_W = IDX_W + 1;
  localparam int NDIR   = arc_pkg::NDIR;

  logic [NDIR-1:0]             cfg_en;
  logic [NDIR-1:0][ADDR_W-1:0] cfg_start;
  logic [NDIR-1:0][SIZE_W-1:0] cfg_len;
  logic [NDIR-1:0][IDX_W-1:0]  sw_idx;
  logic [NDIR-1:0][IDX_W-1:0]  hw_idx;
  logic [NDIR-1:0]             srst;
  logic [NDIR-1:0]             sw_wr;
  logic [NDIR-1:0]             req;
  logic [NDIR-1:0]             adv;
  logic [NDIR-1:0][ADDR_W-1:0] slot_addr;
  logic [NDIR-1:0]             ack;

  arc_regfile #(
    .REG_AW(REG_AW), .BUS_W(BUS_W), .ADDR_W(ADDR_W),
    .IDX_W(IDX_W), .SIZE_W(SIZE_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_wen(reg_wen), .bus_addr(reg_addr), .bus_wdata(reg_wdata),
    .bus_rdata(reg_rdata), .hw_idx(hw_idx),
    .cfg_en(cfg_en), .cfg_start(cfg_start), .cfg_len(cfg_len),
    .sw_idx(sw_idx), .srst(srst), .sw_wr(sw_wr)
  );

  assign ack[arc_pkg::DIR_TX] = tx_fetch_ack;
  assign ack[arc_pkg::DIR_RX] = rx_store_ack;

  for (genvar d = 0; d < NDIR; d++) begin : g_ring
    arc_ring_engine #(
      .IDX_W(IDX_W), .SIZE_W(SIZE_W), .ADDR_W(ADDR_W),
      .STEP(STEP_BYTES), .HW_PRODUCES(d == arc_pkg::DIR_RX)
    ) u_eng (
      .clk(clk), .rst_n(rst_n),
      .en(cfg_en[d]), .start(cfg_start[d]), .len(cfg_len[d]),
      .sw_idx(sw_idx[d]), .srst(srst[d]), .xfer_ack(ack[d]),
      .hw_idx(hw_idx[d]), .req(req[d]), .slot_addr(slot_addr[d]),
      .adv(adv[d])
    );
  end

  assign tx_fetch_req  = req[arc_pkg::DIR_TX];
  assign tx_fetch_addr = slot_addr[arc_pkg::DIR_TX];
  assign rx_store_req  = req[arc_pkg::DIR_RX];
  assign rx_store_addr = slot_addr[arc_pkg::DIR_RX];

  // named events for the bound checker
  logic             tx_adv, rx_adv, tx_srst, rx_srst, rx_cons_wr, tx_en, rx_en;
  logic [IDX_W-1:0] tx_prod, tx_cons, rx_prod, rx_cons;
  logic [SIZE_W-1:0] tx_len, rx_len;
  assign tx_adv     = adv[arc_pkg::DIR_TX];
  assign rx_adv     = adv[arc_pkg::DIR_RX];
  assign tx_srst    = srst[arc_pkg::DIR_TX];
  assign rx_srst    = srst[arc_pkg::DIR_RX];
  assign rx_cons_wr = sw_wr[arc_pkg::DIR_RX];
  assign tx_en      = cfg_en[arc_pkg::DIR_TX];
  assign rx_en      = cfg_en[arc_pkg::DIR_RX];
  assign tx_prod    = sw_idx[arc_pkg::DIR_TX];
  assign tx_cons    = hw_idx[arc_pkg::DIR_TX];
  assign rx_prod    = hw_idx[arc_pkg::DIR_RX];
  assign rx_cons    = sw_idx[arc_pkg::DIR_RX];
  assign tx_len     = cfg_len[arc_pkg::DIR_TX];
  assign rx_len     = cfg_len[arc_pkg::DIR_RX];
endmodule

// File: rtl/arc_checker.sv
module arc_checker #(
  parameter int IDX_W  = 21,
  parameter int SIZE_W = 22,
  parameter int STEP   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tx_en,
  input logic              rx_en,
  input logic [SIZE_W-1:0] tx_len,
  input logic [SIZE_W-1:0] rx_len,
  input logic [IDX_W-1:0]  tx_prod,
  input logic [IDX_W-1:0]  tx_cons,
  input logic [IDX_W-1:0]  rx_prod,
  input logic [IDX_W-1:0]  rx_cons,
  input logic              tx_adv,
  input logic              rx_adv,
  input logic              tx_srst,
  input logic              rx_srst,
  input logic              rx_cons_wr,
  input logic              tx_fetch_req,
  input logic              rx_store_req
);
  // R4: a producer step never lands on the consumer
  a_r4_no_full: assert property (@(posedge clk) disable iff (!rst_n)
    rx_adv && !rx_srst && !rx_cons_wr |=> rx_prod != rx_cons);

  // R3: capture producer moves one step modulo the length
  a_r3_rx_step: assert property (@(posedge clk) disable iff (!rst_n)
    rx_adv && !rx_srst |=> rx_prod ==
      (IDX_W'($past(rx_prod) + IDX_W'(STEP)) & IDX_W'($past(rx_len) - SIZE_W'(1))));

  // R5: playback consumer moves one step modulo the length
  a_r5_tx_step: assert property (@(posedge clk) disable iff (!rst_n)
    tx_adv && !tx_srst |=> tx_cons ==
      (IDX_W'($past(tx_cons) + IDX_W'(STEP)) & IDX_W'($past(tx_len) - SIZE_W'(1))));

  // R6: a stopped direction raises no request
  a_r6_tx_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |-> !tx_fetch_req);
  a_r6_rx_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |-> !rx_store_req);

  // R6/R7: without an advance or soft reset the owned index holds
  a_r7_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_adv && !rx_srst |=> $stable(rx_prod));
  a_r7_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_adv && !tx_srst |=> $stable(tx_cons));

  // R8: soft reset clears both indices of the chosen side
  a_r8_rx_clear: assert property (@(posedge clk) disable iff (!rst_n)
    rx_srst |=> rx_prod == '0 && rx_cons == '0);
  a_r8_tx_clear: assert property (@(posedge clk) disable iff (!rst_n)
    tx_srst |=> tx_prod == '0 && tx_cons == '0);
endmodule

bind audio_ring_ctrl arc_checker #(
  .IDX_W(IDX_W), .SIZE_W(SIZE_W), .STEP(STEP_BYTES)
) u_arc_checker (
  .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .rx_en(rx_en),
  .tx_len(tx_len), .rx_len(rx_len),
  .tx_prod(tx_prod), .tx_cons(tx_cons), .rx_prod(rx_prod), .rx_cons(rx_cons),
  .tx_adv(tx_adv), .rx_adv(rx_adv), .tx_srst(tx_srst), .rx_srst(rx_srst),
  .rx_cons_wr(rx_cons_wr), .tx_fetch_req(tx_fetch_req),
  .rx_store_req(rx_store_req)
);

// File: tb/audio_ring_ctrl_bench.sv
module audio_ring_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wen = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        tx_fetch_req, rx_store_req;
  logic        tx_fetch_ack = 1'b0, rx_store_ack = 1'b0;
  logic [31:0] tx_fetch_addr, rx_store_addr;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  audio_ring_ctrl u_audio_ring_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tx_fetch_req(tx_fetch_req), .tx_fetch_ack(tx_fetch_ack),
    .tx_fetch_addr(tx_fetch_addr), .rx_store_req(rx_store_req),
    .rx_store_ack(rx_store_ack), .rx_store_addr(rx_store_addr)
  );

  // bench model, index 0 = playback, 1 = capture
  bit          m_en[2];
  logic [31:0] m_start[2];
  logic [21:0] m_len[2];
  logic [20:0] m_sw[2];
  logic [20:0] m_hw[2];

  function automatic logic [20:0] f_next(input logic [20:0] i, input logic [21:0] n);
    logic [21:0] t;
    t = ({1'b0, i} + 22'd4) & (n - 22'd1);
    return t[20:0];
  endfunction

  function automatic bit f_txreq();
    return m_en[0] && (m_hw[0] != m_sw[0]);
  endfunction

  function automatic bit f_rxreq();
    return m_en[1] && (f_next(m_hw[1], m_len[1]) != m_sw[1]);
  endfunction

  function automatic logic [31:0] f_rd(input logic [5:0] a);
    int w;
    if (a[1:0] != 2'b00) return 32'd0;
    w = int'(a[5:2]);
    case (w)
      0:  return {31'd0, m_en[0]};
      1:  return m_start[0];
      2:  return {10'd0, m_len[0]};
      3:  return {11'd0, m_sw[0]};
      4:  return {11'd0, m_hw[0]};
      5:  return {31'd0, m_en[1]};
      6:  return m_start[1];
      7:  return {10'd0, m_len[1]};
      8:  return {11'd0, m_hw[1]};
      9:  return {11'd0, m_sw[1]};
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // one cycle: drive, compare outputs with model, then advance the model
  task automatic step(input bit wen, input logic [5:0] a, input logic [31:0] wd,
                      input bit ta, input bit ra);
    bit etx, erx;
    int w;
    @(negedge clk);
    reg_wen = wen; reg_addr = a; reg_wdata = wd;
    tx_fetch_ack = ta; rx_store_ack = ra;
    #1;
    etx = f_txreq();
    erx = f_rxreq();
    chk(tx_fetch_req == etx, "R5 fetch request", 32'(tx_fetch_req), 32'(etx));
    chk(rx_store_req == erx, "R4 store request", 32'(rx_store_req), 32'(erx));
    chk(tx_fetch_addr == m_start[0] + {11'd0, m_hw[0]}, "R5 fetch address",
        tx_fetch_addr, m_start[0] + {11'd0, m_hw[0]});
    chk(rx_store_addr == m_start[1] + {11'd0, m_hw[1]}, "R3 store address",
        rx_store_addr, m_start[1] + {11'd0, m_hw[1]});
    chk(reg_rdata == f_rd(a), "R1 read data", reg_rdata, f_rd(a));
    if (ta && etx) m_hw[0] = f_next(m_hw[0], m_len[0]);
    if (ra && erx) m_hw[1] = f_next(m_hw[1], m_len[1]);
    if (wen && a[1:0] == 2'b00) begin
      w = int'(a[5:2]);
      case (w)
        0: m_en[0] = wd[0];
        1: m_start[0] = wd;
        2: m_len[0] = wd[21:0];
        3: m_sw[0] = wd[20:0];
        5: m_en[1] = wd[0];
        6: m_start[1] = wd;
        7: m_len[1] = wd[21:0];
        9: m_sw[1] = wd[20:0];
        11: begin
          if (wd[0]) begin m_hw[1] = '0; m_sw[1] = '0; end
          if (wd[1]) begin m_hw[0] = '0; m_sw[0] = '0; end
        end
        default: ;
      endcase
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] wd);
    step(1'b1, a, wd, 1'b0, 1'b0);
  endtask

  task automatic rd(input logic [5:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_wen = 0; reg_addr = a; tx_fetch_ack = 0; rx_store_ack = 0;
    #1;
    chk(reg_rdata == exp, tag, reg_rdata, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int d = 0; d < 2; d++) begin
      m_en[d] = 0; m_start[d] = 0; m_len[d] = 0; m_sw[d] = 0; m_hw[d] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R2: reset state
    for (int w = 0; w < 12; w++) rd(6'(w * 4), 32'd0, "R2 register after reset");
    chk(!tx_fetch_req && !rx_store_req, "R2 requests idle", 32'({tx_fetch_req, rx_store_req}), 0);

    // R3/R4: capture fills to one short of full, then stalls
    wr(6'h1C, 32'd16); wr(6'h18, 32'h1000); wr(6'h24, 32'd0); wr(6'h14, 32'd1);
    repeat (5) step(1'b0, 6'h00, 0, 1'b0, 1'b1);
    rd(6'h20, 32'd12, "R4 producer stalls one slot short");
    chk(!rx_store_req, "R4 no request when next equals consumer", 32'(rx_store_req), 0);
    chk(rx_store_addr == 32'h100C, "R3 store address", rx_store_addr, 32'h100C);
    wr(6'h24, 32'd8);
    rd(6'h24, 32'd8, "R1 consumer readback");
    chk(rx_store_req, "R4 resumes after consumer moves", 32'(rx_store_req), 1);
    repeat (3) step(1'b0, 6'h00, 0, 1'b0, 1'b1);
    rd(6'h20, 32'd4, "R9 capture producer wrapped");

    // R5: playback empty, then drains to empty
    wr(6'h08, 32'd32); wr(6'h04, 32'h2000); wr(6'h00, 32'd1);
    rd(6'h10, 32'd0, "R5 consumer start");
    chk(!tx_fetch_req, "R5 empty ring issues no fetch", 32'(tx_fetch_req), 0);
    wr(6'h0C, 32'd8);
    repeat (3) step(1'b0, 6'h00, 0, 1'b1, 1'b0);
    rd(6'h10, 32'd8, "R5 consumer caught up");
    chk(tx_fetch_addr == 32'h2008, "R5 fetch address", tx_fetch_addr, 32'h2008);

    // R7: controller-owned indices ignore writes
    wr(6'h20, 32'h10);
    rd(6'h20, 32'd4, "R7 capture producer write ignored");
    wr(6'h10, 32'h0);
    rd(6'h10, 32'd8, "R7 playback consumer write ignored");

    // R6: disable stops fetches, acks ignored
    wr(6'h0C, 32'd20); wr(6'h00, 32'd0);
    rd(6'h00, 32'd0, "R6 enable readback");
    chk(!tx_fetch_req, "R6 disabled no request", 32'(tx_fetch_req), 0);
    repeat (2) step(1'b0, 6'h00, 0, 1'b1, 1'b0);
    rd(6'h10, 32'd8, "R6 ack without request ignored");
    wr(6'h00, 32'd1);

    // R9: playback consumer wraps around length 32
    wr(6'h0C, 32'd4);
    repeat (9) step(1'b0, 6'h00, 0, 1'b1, 1'b0);
    rd(6'h10, 32'd4, "R9 playback consumer wrapped");
    wr(6'h08, 32'h200000);
    rd(6'h08, 32'h200000, "R9 largest length held");
    wr(6'h08, 32'd32);

    // R8: soft reset per side
    step(1'b1, 6'h2C, 32'd1, 1'b0, 1'b1);
    rd(6'h20, 32'd0, "R8 capture producer cleared");
    rd(6'h24, 32'd0, "R8 capture consumer cleared");
    rd(6'h18, 32'h1000, "R8 capture start kept");
    rd(6'h14, 32'd1, "R8 capture enable kept");
    rd(6'h10, 32'd4, "R8 playback untouched");
    wr(6'h2C, 32'd2);
    rd(6'h0C, 32'd0, "R8 playback producer cleared");
    rd(6'h08, 32'd32, "R8 playback length kept");
    rd(6'h2C, 32'd0, "R1 soft reset reads zero");

    // R1: misaligned access hits nothing
    wr(6'h19, 32'h5555);
    rd(6'h18, 32'h1000, "R1 misaligned write ignored");
    rd(6'h19, 32'd0, "R1 misaligned read zero");

    // constrained random phase
    for (int i = 0; i < 4000; i++) begin
      int k;
      logic [5:0] a;
      logic [31:0] v;
      k = int'($urandom % 16);
      a = 6'($urandom % 12) << 2;
      case (a[5:2])
        4'd2, 4'd7: v = 32'd1 << (4 + ($urandom % 3));
        4'd0, 4'd5: v = (($urandom % 8) != 0) ? 32'd1 : 32'd0;
        4'd11:      v = (($urandom % 6) == 0) ? 32'($urandom % 4) : 32'd0;
        default:    v = $urandom & 32'h3C;
      endcase
      step(k < 5, a, v, $urandom % 4 != 0, $urandom % 4 != 0);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule